// File: doc/BRIEF.md
# Immediate-Sequence Folding Unit

This unit sits between a small register-based window of instruction bytes and the execute stage of a 32-bit stack processor. On every cycle it looks at the bytes at the head of the window. An immediate opcode has bit 7 set and carries a 7-bit payload in bits 6:0. The unit takes the contiguous run of valid immediate bytes at the head, up to five of them, and folds the run into one 32-bit result. It then offers that result to the execute stage as a single stack action, together with the number of bytes the action consumes.

The unit keeps the immediate-continuation flag as a two-state machine. `ST_OPEN` means the flag is clear. `ST_CHAIN` means the flag is set. It has four named transitions:
- `T_START` (`ST_OPEN` to `ST_CHAIN`) happens when a push is consumed.
- `T_EXTEND` (`ST_CHAIN` to `ST_CHAIN`) happens when a replace-top is consumed.
- `T_BREAK` (either state to `ST_OPEN`) happens when a non-immediate byte is consumed.
- `T_FLUSH` (either state to `ST_OPEN`) happens when a branch flush arrives.

In `ST_OPEN` the first payload is sign-extended and pushed, and the rest of the run is shifted in below it. In `ST_CHAIN` the current top of stack is shifted left by 7 bits per byte, the payloads are merged into the low bits, and the result is issued as a replace-top. Because of this, a run that is split across two windows still builds the same constant as an unsplit run.

Top module: `imm_fold_unit`

## Requirements
- R1: After reset, `chain_flag` is 0. With no valid head byte, `fold_act` is NONE (code 0) and `fold_count` is 0.
- R2: In the open state, a run of n valid immediates produces PUSH (code 1) with `fold_count`=n. The value is the first payload sign-extended from bit 6, with each later payload shifted in 7 bits at a time. Consuming the action sets `chain_flag`.
- R3: In the chain state, a run of n immediates produces REPLACE (code 2) with the value `(stack_top << 7*n) | payloads`. The first byte of the run supplies the most significant payload. `chain_flag` stays set after consumption.
- R4: The run starts at byte 0 (`win_bytes[7:0]`, valid bit `win_valid[0]`), with byte i at bits 8i+7:8i. The run ends at the first byte that is invalid or has bit 7 clear, or after five bytes. `fold_count` equals the run length.
- R5: A valid non-immediate head byte produces PASS (code 3) with `fold_count`=1 and `fold_value`=0. Consuming it clears `chain_flag`.
- R6: When the head byte is invalid, the unit issues NONE with count 0 and value 0, and `chain_flag` keeps its value even while `exec_ready` is high.
- R7: While `exec_ready` is 0, the unit continues to present its action and `chain_flag` does not change.
- R8: While `flush` is 1, the unit issues NONE with count 0 and value 0, and `chain_flag` is 0 on the next cycle, regardless of `exec_ready`.
- R9: A run of more than five immediates folds only its first five bytes. The next cycle continues the run as a REPLACE, so that two windows build the same value as one long shift chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_bytes | input | 40 | Window bytes, head at bits 7:0 |
| win_valid | input | 5 | Per-byte valid, bit i for byte i |
| stack_top | input | 32 | Current top-of-stack value |
| exec_ready | input | 1 | Execute stage consumes the offered action this cycle |
| flush | input | 1 | Branch flush: drop the action and clear the flag |
| fold_act | output | 2 | 0 NONE, 1 PUSH, 2 REPLACE, 3 PASS |
| fold_count | output | 3 | Bytes consumed by the action |
| fold_value | output | 32 | Folded value for PUSH or REPLACE, else 0 |
| chain_flag | output | 1 | Continuation flag (state is `ST_CHAIN`) |

## Verification
The bench builds the unit with its defaults: a five-byte window, 7-bit payloads and a 32-bit value. With these settings a single window can carry a complete 32-bit constant such as 0xDEADBEEF, and a sixth immediate can spill into the next window. The 32-bit width also makes truncation visible when a full top of stack is shifted left in the chain state. A five-byte window lets the run stop either at a gap in the valid bits or at a non-immediate byte placed behind immediates.

// File: rtl/fold_pkg.sv
package fold_pkg;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_PUSH    = 2'd1,
        ACT_REPLACE = 2'd2,
        ACT_PASS    = 2'd3
    } fold_act_e;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_CHAIN = 1'b1
    } fold_state_e;

endpackage

// File: rtl/fold_run_scan.sv
module fold_run_scan #(
    parameter int FOLD_MAX = 5,
    localparam int CNT_W = $clog2(FOLD_MAX + 1)
) (
    input  logic [FOLD_MAX-1:0] is_imm,
    input  logic [FOLD_MAX-1:0] byte_valid,
    output logic [CNT_W-1:0]    run_len
);

    always_comb begin
        logic stopped;
        stopped = 1'b0;
        run_len = '0;
        for (int i = 0; i < FOLD_MAX; i++) begin
            if (!stopped && byte_valid[i] && is_imm[i]) begin
                run_len = run_len + CNT_W'(1);
            end else begin
                stopped = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fold_merge.sv
module fold_merge #(
    parameter int FOLD_MAX = 5,
    parameter int PAY_W    = 7,
    parameter int DATA_W   = 32,
    localparam int CNT_W = $clog2(FOLD_MAX + 1)
) (
    input  logic [FOLD_MAX*PAY_W-1:0] payloads,
    input  logic [CNT_W-1:0]          run_len,
    input  logic                      chain,
    input  logic [DATA_W-1:0]         stack_top,
    output logic [DATA_W-1:0]         merged
);

    always_comb begin
        logic [PAY_W-1:0] head;
        head = payloads[PAY_W-1:0];
        if (chain) begin
            merged = (stack_top << PAY_W) | DATA_W'(head);
        end else begin
            merged = {{(DATA_W-PAY_W){head[PAY_W-1]}}, head};
        end
        for (int i = 1; i < FOLD_MAX; i++) begin
            if (i < int'(run_len)) begin
                merged = (merged << PAY_W) | DATA_W'(payloads[i*PAY_W +: PAY_W]);
            end
        end
    end

endmodule

// File: rtl/imm_fold_unit.sv
module imm_fold_unit
    import fold_pkg::*;
#(
    parameter int FOLD_MAX = 5,
    parameter int PAY_W    = 7,
    parameter int DATA_W   = 32,
    localparam int BYTE_W = PAY_W + 1,
    localparam int CNT_W  = $clog2(FOLD_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FOLD_MAX*BYTE_W-1:0] win_bytes,
    input  logic [FOLD_MAX-1:0]        win_valid,
    input  logic [DATA_W-1:0]          stack_top,
    input  logic                       exec_ready,
    input  logic                       flush,
    output logic [1:0]                 fold_act,
    output logic [CNT_W-1:0]           fold_count,
    output logic [DATA_W-1:0]          fold_value,
    output logic                       chain_flag
);

    fold_state_e state_q, state_d;
    fold_act_e   act;

    logic [FOLD_MAX-1:0]       is_imm;
    logic [FOLD_MAX*PAY_W-1:0] payloads;
    logic [CNT_W-1:0]          run_len;
    logic [DATA_W-1:0]         merged;
    logic                      fire;

    // Split each window byte into its immediate marker and its payload.
    for (genvar g = 0; g < FOLD_MAX; g++) begin : g_split
        assign is_imm[g]                   = win_bytes[g*BYTE_W + PAY_W];
        assign payloads[g*PAY_W +: PAY_W]  = win_bytes[g*BYTE_W +: PAY_W];
    end

    fold_run_scan #(.FOLD_MAX(FOLD_MAX)) scan_i (
        .is_imm     (is_imm),
        .byte_valid (win_valid),
        .run_len    (run_len)
    );

    fold_merge #(.FOLD_MAX(FOLD_MAX), .PAY_W(PAY_W), .DATA_W(DATA_W)) merge_i (
        .payloads  (payloads),
        .run_len   (run_len),
        .chain     (state_q == ST_CHAIN),
        .stack_top (stack_top),
        .merged    (merged)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Outputs and next state.
    always_comb begin
        act        = ACT_NONE;
        fold_count = '0;
        fold_value = '0;
        if (!flush && win_valid[0]) begin
            if (!is_imm[0]) begin
                act        = ACT_PASS;
                fold_count = CNT_W'(1);
            end else begin
                fold_count = run_len;
                fold_value = merged;
                unique case (state_q)
                    ST_OPEN:  act = ACT_PUSH;
                    ST_CHAIN: act = ACT_REPLACE;
                    default:  act = ACT_NONE;
                endcase
            end
        end
        fire    = exec_ready && (act != ACT_NONE);
        state_d = state_q;
        if (flush) begin
            state_d = ST_OPEN;                       // T_FLUSH
        end else if (fire) begin
            unique case (act)
                ACT_PUSH:    state_d = ST_CHAIN;     // T_START
                ACT_REPLACE: state_d = ST_CHAIN;     // T_EXTEND
                ACT_PASS:    state_d = ST_OPEN;      // T_BREAK
                default:     state_d = state_q;
            endcase
        end
    end

    assign fold_act   = act;
    assign chain_flag = (state_q == ST_CHAIN);

    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fold_act == 2'd1 || fold_act == 2'd2) |->
            (fold_count >= CNT_W'(1) && fold_count <= CNT_W'(FOLD_MAX)));

    assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !chain_flag);

    assert_push_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ready && !flush && fold_act == 2'd1) |=> chain_flag);

    assert_pass_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ready && !flush && fold_act == 2'd3) |=> !chain_flag);

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_ready && !flush) |=> $stable(chain_flag));

    assert_replace_in_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fold_act == 2'd2) |-> chain_flag);

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid[0] && !flush) |=> $stable(chain_flag));

endmodule

// File: tb/imm_fold_unit_tb_top.sv
module imm_fold_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] win_bytes = '0;
    logic [4:0]  win_valid = '0;
    logic [31:0] stack_top = '0;
    logic        exec_ready = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  fold_act;
    logic [2:0]  fold_count;
    logic [31:0] fold_value;
    logic        chain_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    imm_fold_unit dut_i (
        .clk(clk), .rst_n(rst_n), .win_bytes(win_bytes), .win_valid(win_valid),
        .stack_top(stack_top), .exec_ready(exec_ready), .flush(flush),
        .fold_act(fold_act), .fold_count(fold_count), .fold_value(fold_value),
        .chain_flag(chain_flag)
    );

    typedef struct packed {
        logic        fl;
        logic        rdy;
        logic [4:0]  vld;
        logic [39:0] win;
        logic [31:0] tos;
        logic        eflag;
        logic [1:0]  eact;
        logic [2:0]  ecnt;
        logic [31:0] eval;
    } vec_t;

    localparam int NV = 22;
    // act codes: 0 NONE, 1 PUSH, 2 REPLACE, 3 PASS
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,5'b00000,40'h0,          32'h0,       1'b0,2'd0,3'd0,32'h0},        // R6
        '{1'b0,1'b1,5'b00011,40'h0000000B81, 32'h0,       1'b0,2'd1,3'd1,32'h1},        // R2
        '{1'b0,1'b1,5'b00001,40'h0B,         32'h0,       1'b1,2'd3,3'd1,32'h0},        // R5
        '{1'b0,1'b0,5'b00001,40'hFF,         32'h0,       1'b0,2'd1,3'd1,32'hFFFFFFFF}, // R7
        '{1'b0,1'b1,5'b00001,40'hFF,         32'h0,       1'b0,2'd1,3'd1,32'hFFFFFFFF}, // R2
        '{1'b0,1'b1,5'b00001,40'h85,         32'h12345678,1'b1,2'd2,3'd1,32'h1A2B3C05}, // R3
        '{1'b1,1'b1,5'b00001,40'h81,         32'h0,       1'b1,2'd0,3'd0,32'h0},        // R8
        '{1'b0,1'b1,5'b11111,40'hEFFDB6F58D, 32'h0,       1'b0,2'd1,3'd5,32'hDEADBEEF}, // R2
        '{1'b0,1'b1,5'b00001,40'h0B,         32'h0,       1'b1,2'd3,3'd1,32'h0},        // R5
        '{1'b0,1'b1,5'b11111,40'h8080808080, 32'h0,       1'b0,2'd1,3'd5,32'h0},        // R9
        '{1'b0,1'b1,5'b00001,40'h83,         32'h0,       1'b1,2'd2,3'd1,32'h3},        // R9
        '{1'b0,1'b1,5'b00001,40'h0B,         32'h0,       1'b1,2'd3,3'd1,32'h0},        // R5
        '{1'b0,1'b1,5'b11011,40'h0000838281, 32'h0,       1'b0,2'd1,3'd2,32'h82},       // R4
        '{1'b0,1'b1,5'b00001,40'h0B,         32'h0,       1'b1,2'd3,3'd1,32'h0},        // R5
        '{1'b0,1'b1,5'b00011,40'h01C0,       32'h0,       1'b0,2'd1,3'd1,32'hFFFFFFC0}, // R4
        '{1'b0,1'b1,5'b00001,40'h01,         32'h0,       1'b1,2'd3,3'd1,32'h0},        // R5
        '{1'b0,1'b1,5'b00001,40'h81,         32'h0,       1'b0,2'd1,3'd1,32'h1},        // R2
        '{1'b0,1'b1,5'b00111,40'h838281,     32'hFFFFFFFF,1'b1,2'd2,3'd3,32'hFFE04103}, // R3
        '{1'b0,1'b1,5'b11110,40'h8181818181, 32'h0,       1'b1,2'd0,3'd0,32'h0},        // R6
        '{1'b1,1'b1,5'b00000,40'h0,          32'h0,       1'b1,2'd0,3'd0,32'h0},        // R8
        '{1'b0,1'b1,5'b00000,40'h0,          32'h0,       1'b0,2'd0,3'd0,32'h0},        // R8
        '{1'b0,1'b0,5'b00001,40'h0B,         32'h0,       1'b0,2'd3,3'd1,32'h0}         // R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 flag at reset", 32'(chain_flag), 32'h0);
        check("R1 act at reset", 32'(fold_act), 32'h0);
        check("R1 count at reset", 32'(fold_count), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            flush      = VECS[v].fl;
            exec_ready = VECS[v].rdy;
            win_valid  = VECS[v].vld;
            win_bytes  = VECS[v].win;
            stack_top  = VECS[v].tos;
            #1;
            check($sformatf("vec%0d flag", v),  32'(chain_flag), 32'(VECS[v].eflag));
            check($sformatf("vec%0d act", v),   32'(fold_act),   32'(VECS[v].eact));
            check($sformatf("vec%0d count", v), 32'(fold_count), 32'(VECS[v].ecnt));
            check($sformatf("vec%0d value", v), fold_value,      VECS[v].eval);
        end

        // R7: the stalled PASS of the last vector left the flag clear; now set it and stall.
        @(negedge clk);
        exec_ready = 1'b1; flush = 1'b0; win_valid = 5'b00001; win_bytes = 40'h81;
        @(negedge clk);
        exec_ready = 1'b0; win_bytes = 40'h0B;
        #1;
        check("R2 flag after push", 32'(chain_flag), 32'h1);
        @(negedge clk);
        #1;
        check("R7 flag held while stalled PASS", 32'(chain_flag), 32'h1);

        // R1: reset while in chain state returns to open.
        rst_n = 1'b0;
        win_valid = 5'b00000;
        #1;
        check("R1 flag cleared by reset", 32'(chain_flag), 32'h0);
        check("R1 act during reset", 32'(fold_act), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        win_valid = 5'b00001; win_bytes = 40'h85; exec_ready = 1'b1;
        #1;
        check("R1 push after reset", 32'(fold_act), 32'h1);
        check("R1 value after reset", fold_value, 32'h5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule